// File: doc/BRIEF.md
# Time-Counter Compare Channels

This block watches a free-running time counter and compares it against a programmable value in each of up to four channels. When the counter reaches a channel's armed value, the channel latches an event flag, can raise the shared interrupt, can raise a per-channel DMA request, and drives its output pin. The pin either toggles on every match or gives a single-cycle high pulse. A periodic output is built by loading a first value while the channel is idle, switching on an output mode, and queueing the next value. A queued value takes over automatically when the active one matches, so software only has to refill the queue once per event.

Software reaches the block through a single-cycle register port. Each channel has a control word and a compare word, eight bytes apart. A shared status word mirrors every channel's event flag. Event flags are cleared by writing a one to them. Writing a zero mode field stops the channel and drops any armed or queued value. The counter is 31 bits wide and a compare word with bit 31 set can never match.

Top module: `tcmp_unit`

## Requirements
- R1: After reset every event flag, pin, interrupt and DMA request is 0. The status word reads 0 and compare words read 0.
- R2: The channel control word at 0x608+8n reads back as follows: DMA enable in bit 0, mode in bits 5:2, interrupt enable in bit 6, event flag in bit 7. Bit 1 and bits 31:8 read as 0.
- R3: A channel matches only when its mode is non-zero, a value is armed, and the 32-bit compare value equals the zero-extended 31-bit counter. A value with bit 31 set never matches.
- R4: On a match the event flag reads 1 after the next clock edge. Writing the control word with bit 7 set clears it. Nothing else clears it.
- R5: In mode 0x5 the channel pin inverts on every match.
- R6: In mode 0xF the channel pin is high for exactly one cycle per match.
- R7: A compare write (0x60C+8n) while the mode is 0 arms that value. A compare write while the mode is non-zero and a value is armed is held in the queue. On a match the queued value becomes active. The compare word reads the active value.
- R8: A match with nothing queued leaves the active value unchanged, and that value matches again the next time the counter reaches it.
- R9: Writing a control word with mode 0 disarms the channel. No match occurs until a new value is armed.
- R10: The status word at 0x604 holds channel n's event flag in bit n. Its upper bits read 0.
- R11: The interrupt output is high exactly when some channel has both its flag and its interrupt enable set. Channel n's DMA request is its flag ANDed with its DMA enable.
- R12: A compare write while the mode is non-zero and nothing is armed is ignored.
- R13: A counter that stays at the matching value produces one event. A flag cleared while the counter stays there remains clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Current time counter value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| cmp_pin_o | output | NUM_CH | Per-channel compare outputs |
| irq_o | output | 1 | Combined compare interrupt |
| dma_req_o | output | NUM_CH | Per-channel DMA requests |

## Verification
Faults in the armed, queued or edge-detect state show up at the ports in different ways. A missing event leaves the flag and status bit at 0 one edge after the counter reaches the value. A spurious event sets them when the mode is zero, nothing is armed or the counter is held. A wrong promotion shows as a stale compare readback right after a match. Pin faults appear on the pin in the same cycle as the flag: a pulse that lasts two cycles, or a toggle that does not invert.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int STAT_OFS  = 'h604;
  localparam int CH_BASE   = 'h608;
  localparam int CH_STRIDE = 8;
  localparam int CMP_OFS   = 4;

  localparam int CTL_DMA  = 0;
  localparam int CTL_MODE = 2;
  localparam int CTL_IE   = 6;
  localparam int CTL_FLAG = 7;

  localparam logic [3:0] MODE_OFF    = 4'h0;
  localparam logic [3:0] MODE_TOGGLE = 4'h5;
  localparam logic [3:0] MODE_PULSE  = 4'hF;
endpackage

// File: rtl/tcmp_rstsync.sv
module tcmp_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tcmp_regdec.sv
module tcmp_regdec
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              stat_hit,
  output logic [NUM_CH-1:0] ctrl_hit,
  output logic [NUM_CH-1:0] cmp_hit
);
  assign stat_hit = (addr == ADDR_W'(STAT_OFS));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    localparam int CTRL_ADDR = CH_BASE + n * CH_STRIDE;
    assign ctrl_hit[n] = (addr == ADDR_W'(CTRL_ADDR));
    assign cmp_hit[n]  = (addr == ADDR_W'(CTRL_ADDR + CMP_OFS));
  end
endmodule

// File: rtl/tcmp_chan.sv
module tcmp_chan
  import tcmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ctrl_we,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [7:0]        ctrl_rd,
  output logic [DATA_W-1:0] cmp_rd,
  output logic              flag_o,
  output logic              pin_o,
  output logic              irq_o,
  output logic              dma_o
);
  logic              dma_q, dma_n;
  logic [3:0]        mode_q, mode_n;
  logic              ie_q, ie_n;
  logic              flag_q, flag_n;
  logic [DATA_W-1:0] act_q, act_n;
  logic [DATA_W-1:0] que_q, que_n;
  logic              pend_q, pend_n;
  logic              armed_q, armed_n;
  logic              eq_q, eq_n;
  logic              pin_q, pin_n;
  logic              eq, fire;

  always_comb begin
    eq      = armed_q && (mode_q != MODE_OFF) && (DATA_W'(cnt_i) == act_q);
    fire    = eq && !eq_q;
    eq_n    = eq;
    dma_n   = dma_q;
    mode_n  = mode_q;
    ie_n    = ie_q;
    act_n   = act_q;
    que_n   = que_q;
    pend_n  = pend_q;
    armed_n = armed_q;

    if (fire && pend_q) begin
      act_n  = que_q;
      pend_n = 1'b0;
    end

    if (ctrl_we) begin
      dma_n  = wdata[CTL_DMA];
      mode_n = wdata[CTL_MODE +: 4];
      ie_n   = wdata[CTL_IE];
      if (wdata[CTL_MODE +: 4] == MODE_OFF) begin
        armed_n = 1'b0;
        pend_n  = 1'b0;
      end
    end

    if (cmp_we) begin
      if (mode_q == MODE_OFF) begin
        act_n   = wdata;
        armed_n = 1'b1;
        pend_n  = 1'b0;
      end else if (armed_q) begin
        que_n  = wdata;
        pend_n = 1'b1;
      end
    end

    if (fire)                          flag_n = 1'b1;
    else if (ctrl_we && wdata[CTL_FLAG]) flag_n = 1'b0;
    else                               flag_n = flag_q;

    case (mode_q)
      MODE_TOGGLE: pin_n = fire ? !pin_q : pin_q;
      MODE_PULSE:  pin_n = fire;
      default:     pin_n = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q   <= 1'b0;
      mode_q  <= MODE_OFF;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      act_q   <= '0;
      que_q   <= '0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      eq_q    <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      if (ctrl_we) begin
        dma_q  <= dma_n;
        mode_q <= mode_n;
        ie_q   <= ie_n;
      end
      if (cmp_we || fire) begin
        act_q <= act_n;
        que_q <= que_n;
      end
      pend_q  <= pend_n;
      armed_q <= armed_n;
      flag_q  <= flag_n;
      eq_q    <= eq_n;
      pin_q   <= pin_n;
    end
  end

  assign ctrl_rd = {flag_q, ie_q, mode_q, 1'b0, dma_q};
  assign cmp_rd  = act_q;
  assign flag_o  = flag_q;
  assign pin_o   = pin_q;
  assign irq_o   = flag_q && ie_q;
  assign dma_o   = flag_q && dma_q;
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 31,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] cmp_pin_o,
  output logic              irq_o,
  output logic [NUM_CH-1:0] dma_req_o
);
  logic                         rst_sync_n;
  logic                         stat_hit;
  logic [NUM_CH-1:0]            ctrl_hit, cmp_hit;
  logic [NUM_CH-1:0][7:0]       ctrl_rd;
  logic [NUM_CH-1:0][DATA_W-1:0] cmp_rd;
  logic [NUM_CH-1:0]            flag_vec, irq_vec;

  tcmp_rstsync #(.STAGES(2)) i_rstsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tcmp_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_regdec (
    .addr(reg_addr), .stat_hit(stat_hit), .ctrl_hit(ctrl_hit), .cmp_hit(cmp_hit)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    tcmp_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chan (
      .clk(clk),
      .rst_n(rst_sync_n),
      .cnt_i(cnt_i),
      .ctrl_we(reg_we && ctrl_hit[n]),
      .cmp_we(reg_we && cmp_hit[n]),
      .wdata(reg_wdata),
      .ctrl_rd(ctrl_rd[n]),
      .cmp_rd(cmp_rd[n]),
      .flag_o(flag_vec[n]),
      .pin_o(cmp_pin_o[n]),
      .irq_o(irq_vec[n]),
      .dma_o(dma_req_o[n])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (stat_hit) reg_rdata = DATA_W'(flag_vec);
    for (int n = 0; n < NUM_CH; n++) begin
      if (ctrl_hit[n]) reg_rdata = DATA_W'(ctrl_rd[n]);
      if (cmp_hit[n])  reg_rdata = cmp_rd[n];
    end
  end

  assign irq_o = |irq_vec;
endmodule

// File: rtl/tcmp_chk.sv
module tcmp_chk
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_we,
  input logic [NUM_CH-1:0][7:0] ctrl_rd,
  input logic [NUM_CH-1:0]      flag_vec,
  input logic [NUM_CH-1:0]      pin_o,
  input logic                   irq_o
);
  assert_irq_has_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_vec != '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    assert_flag_needs_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_rd[n][CTL_FLAG]) |-> ($past(ctrl_rd[n][CTL_MODE +: 4]) != MODE_OFF));

    assert_flag_clear_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_rd[n][CTL_FLAG]) |-> $past(reg_we));

    assert_toggle_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_o[n] != $past(pin_o[n])) && ($past(ctrl_rd[n][CTL_MODE +: 4]) == MODE_TOGGLE))
      |-> ctrl_rd[n][CTL_FLAG]);

    assert_pulse_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_o[n] && (ctrl_rd[n][CTL_MODE +: 4] == MODE_PULSE)) |=> !pin_o[n]);
  end
endmodule

bind tcmp_unit tcmp_chk #(.NUM_CH(NUM_CH)) i_tcmp_chk (
  .clk(clk),
  .rst_n(rst_n),
  .reg_we(reg_we),
  .ctrl_rd(ctrl_rd),
  .flag_vec(flag_vec),
  .pin_o(cmp_pin_o),
  .irq_o(irq_o)
);

// File: tb/test_tcmp_unit.sv
module test_tcmp_unit;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 31;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_STAT = 12'h604;

  logic              clk;
  logic              rst_n;
  logic [CNT_W-1:0]  cnt_i;
  logic              reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic [NUM_CH-1:0] cmp_pin_o;
  logic              irq_o;
  logic [NUM_CH-1:0] dma_req_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // scoreboard queues: 0 = read data, 1 = pins, 2 = interrupt, 3 = dma
  int          q_sel[$];
  logic [31:0] q_exp[$];
  string       q_req[$];

  tcmp_unit #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_tcmp_unit (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_pin_o(cmp_pin_o),
    .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [ADDR_W-1:0] a_ctl(int n);
    return ADDR_W'('h608 + 8 * n);
  endfunction
  function automatic logic [ADDR_W-1:0] a_cmp(int n);
    return ADDR_W'('h60C + 8 * n);
  endfunction

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic tick(int v);
    @(negedge clk);
    cnt_i = CNT_W'(v);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic exp_rd(logic [ADDR_W-1:0] a, logic [31:0] e, string r);
    reg_addr = a;
    q_sel.push_back(0); q_exp.push_back(e); q_req.push_back(r);
  endtask

  task automatic exp_sig(int s, logic [31:0] e, string r);
    q_sel.push_back(s); q_exp.push_back(e); q_req.push_back(r);
  endtask

  // monitor: compares queued expectations after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q_sel.size() > 0) begin
        int s;
        logic [31:0] e, act;
        string r;
        s = q_sel.pop_front(); e = q_exp.pop_front(); r = q_req.pop_front();
        case (s)
          0:       act = reg_rdata;
          1:       act = 32'(cmp_pin_o);
          2:       act = 32'(irq_o);
          default: act = 32'(dma_req_o);
        endcase
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", r, s, act, e);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; cnt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    exp_rd(A_STAT, 32'h0, "R1"); exp_sig(1, 0, "R1"); exp_sig(2, 0, "R1"); exp_sig(3, 0, "R1");
    idle();
    exp_rd(a_cmp(0), 32'h0, "R1");
    idle();

    // R2 control field readback
    wr(a_ctl(1), 32'h0000_0055);
    exp_rd(a_ctl(1), 32'h55, "R2");
    wr(a_ctl(1), 32'hFFFF_FF7E);
    exp_rd(a_ctl(1), 32'h7C, "R2");
    wr(a_ctl(1), 32'h0);

    // R7 arm, queue, promote; R5 toggle; R4 flag
    wr(a_ctl(0), 32'h0);
    wr(a_cmp(0), 32'd100);
    exp_rd(a_cmp(0), 32'd100, "R7");
    wr(a_ctl(0), 32'h54);
    wr(a_cmp(0), 32'd200);
    exp_rd(a_cmp(0), 32'd100, "R7");
    tick(100);
    exp_rd(a_ctl(0), 32'hD4, "R4"); exp_sig(1, 32'h1, "R5"); exp_sig(2, 1, "R11");
    idle();
    exp_rd(a_cmp(0), 32'd200, "R7");
    tick(101);
    exp_rd(A_STAT, 32'h1, "R10");
    tick(200);
    exp_rd(a_cmp(0), 32'd200, "R8"); exp_sig(1, 32'h0, "R5");
    wr(a_ctl(0), 32'hD4);
    exp_rd(a_ctl(0), 32'h54, "R13"); exp_sig(2, 0, "R11");
    tick(5);
    tick(200);
    exp_rd(a_cmp(0), 32'd200, "R8"); exp_sig(1, 32'h1, "R8");
    wr(a_ctl(0), 32'hD4);
    tick(0);

    // R6 pulse mode on channel 1
    wr(a_ctl(1), 32'h0);
    wr(a_cmp(1), 32'd300);
    wr(a_ctl(1), 32'h3C);
    tick(300);
    exp_rd(A_STAT, 32'h2, "R10"); exp_sig(1, 32'h3, "R6"); exp_sig(2, 0, "R11");
    idle();
    exp_sig(1, 32'h1, "R6");
    wr(a_ctl(1), 32'h3D);
    exp_sig(3, 32'h2, "R11");
    wr(a_ctl(1), 32'hBD);
    exp_sig(3, 32'h0, "R11");

    // R3 compare word with bit 31 never matches
    wr(a_ctl(2), 32'h0);
    wr(a_cmp(2), 32'h8000_0032);
    wr(a_ctl(2), 32'h14);
    tick(50);
    exp_rd(a_ctl(2), 32'h14, "R3"); exp_sig(1, 32'h1, "R3");

    // R3 mode zero never matches; R9 disable; R12 ignored write
    wr(a_ctl(3), 32'h0);
    wr(a_cmp(3), 32'd60);
    tick(60);
    exp_rd(a_ctl(3), 32'h0, "R3");
    tick(61);
    wr(a_ctl(3), 32'h14);
    wr(a_ctl(3), 32'h0);
    wr(a_ctl(3), 32'h14);
    tick(60);
    exp_rd(a_ctl(3), 32'h14, "R9");
    wr(a_cmp(3), 32'd70);
    exp_rd(a_cmp(3), 32'd60, "R12");
    tick(70);
    exp_rd(a_ctl(3), 32'h14, "R12");

    // R10 two channels matching together
    wr(a_ctl(2), 32'h0);
    wr(a_cmp(2), 32'd200);
    wr(a_ctl(2), 32'h14);
    tick(200);
    exp_rd(A_STAT, 32'h5, "R10"); exp_sig(1, 32'h4, "R5"); exp_sig(2, 1, "R11");
    idle();
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule